// File: doc/BRIEF.md
# Inter-Processor Doorbell Controller

This block is a bank of doorbell bits that processors use to signal one another. It holds several independent instances. Each instance has 32 one-bit channels, a pending word and an enable word. Software never writes either word directly. A set register turns bits on, a clear register turns bits off, and a value register reads the current word back.

Each instance drives its own interrupt line. The line is high while any channel is both pending and enabled. For each instance the block also shows a "send permitted" word. A sender may ring a channel only when that channel is enabled and not already pending; otherwise the attempt counts as busy.

Access goes through a simple memory-mapped port. The port takes a select, a write enable, an address and write data. It answers one cycle later with a ready pulse and, for reads, the read data.

Top module: `doorbell_mailbox`

## Requirements
- R1: Under synchronous active-low reset, every pending and enable bit clears, every interrupt line goes low and every send-permitted bit is 0.
- R2: Writing to a set register sets each bit that is 1 in the write data, in the matching pending or enable word, at the accepting clock edge. Bits that are 0 in the write data keep their value.
- R3: Writing to a clear register clears each bit that is 1 in the write data. Bits that are 0 in the write data keep their value.
- R4: Byte addresses are 0x04 + 0x20·b + 4·i, where i is the instance (0 to 3) and b selects the bank: 0 pending value, 1 pending set, 2 pending clear, 3 enable value, 4 enable set, 5 enable clear. Bit n of each register is channel n.
- R5: Reading a set register, a clear register or an unmapped address returns 0. A write to a value register or to an unmapped address changes no state. Unmapped addresses include misaligned ones, those below 0x04, and those beyond bank 5 or instance 3.
- R6: The interrupt line of instance i is high exactly when (pending AND enable) of that instance is non-zero. It is registered, so it changes one clock edge after the edge that changed the state.
- R7: Bits [32·i+31:32·i] of send_ok equal enable AND NOT pending for instance i, and they follow the state at the same edge that the state changes.
- R8: A selected access raises bus_ready for exactly the cycle after the accepting edge. A read's data is valid on bus_rdata in that cycle. At all other times, and after writes, bus_rdata is 0.
- R9: Instances are independent. A write addressed to one instance leaves the words of every other instance unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | Access completion pulse |
| irq | output | 4 | One interrupt line per instance |
| send_ok | output | 128 | Per-instance enable AND NOT pending, 32 bits per instance |

## Verification
The set and clear paths are driven with sparse and dense bit patterns. Follow-up writes carry different bits, which separates OR-in and AND-out behaviour from plain overwrites. Distinct patterns go to all four instances and are read back, which exposes any swap of bank or instance in the address decode. Writes to value registers, misaligned addresses and out-of-range addresses are followed by read-backs, to show that nothing changed. Interrupt lines are sampled both in the cycle right after a write and one cycle later. A pending bit on a disabled channel is also tested, which separates "any pending" from "pending and enabled".

// File: rtl/doorbell_pkg.sv
// Package: shared constants and the register bank encoding for the doorbell
// controller. The bank index order is decoded from the address, so it is fixed.
package doorbell_pkg;

    localparam int unsigned BASE_OFF    = 4;   // byte offset of the first bank
    localparam int unsigned BANK_STRIDE = 32;  // bytes between banks
    localparam int unsigned REG_STRIDE  = 4;   // bytes between instances in a bank
    localparam int unsigned NUM_BANKS   = 6;

    typedef enum logic [2:0] {
        BK_PND_VAL = 3'd0,
        BK_PND_SET = 3'd1,
        BK_PND_CLR = 3'd2,
        BK_EN_VAL  = 3'd3,
        BK_EN_SET  = 3'd4,
        BK_EN_CLR  = 3'd5
    } bank_e;

endpackage

// File: rtl/doorbell_decode.sv
// Module: doorbell_decode
// Purpose: turns a byte address into a bank code, an instance index and a hit
// flag. Misaligned addresses, addresses below the base, and addresses beyond
// the last bank or instance do not hit.
// Assumes: ADDR_W >= 8 and NUM_INST * REG_STRIDE <= BANK_STRIDE.
module doorbell_decode
    import doorbell_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned NUM_INST = 4
) (
    input  logic [ADDR_W-1:0]                                            addr_i,
    output logic                                                         hit_o,
    output bank_e                                                        bank_o,
    output logic [$clog2(BANK_STRIDE)-$clog2(REG_STRIDE)-1:0]            inst_o
);
    localparam int unsigned BANK_SH = $clog2(BANK_STRIDE);
    localparam int unsigned REG_SH  = $clog2(REG_STRIDE);
    localparam int unsigned IDX_W   = BANK_SH - REG_SH;
    localparam int unsigned BNK_W   = ADDR_W - BANK_SH;

    logic [ADDR_W-1:0] off;
    logic [BNK_W-1:0]  bank_raw;
    logic [IDX_W-1:0]  idx;
    logic              below, aligned;

    // Split the base-relative offset into bank, instance and byte fields.
    always_comb begin
        below    = addr_i < ADDR_W'(BASE_OFF);
        off      = addr_i - ADDR_W'(BASE_OFF);
        bank_raw = off[ADDR_W-1:BANK_SH];
        idx      = off[BANK_SH-1:REG_SH];
        aligned  = (off[REG_SH-1:0] == '0);
        hit_o    = !below && aligned && (bank_raw < BNK_W'(NUM_BANKS))
                   && (idx < IDX_W'(NUM_INST));
        bank_o   = bank_e'(bank_raw[2:0]);
        inst_o   = idx;
    end

endmodule

// File: rtl/doorbell_chan_bank.sv
// Module: doorbell_chan_bank
// Purpose: the state of one instance. It holds the pending and enable words,
// each changed only through set and clear masks, plus the registered
// interrupt line and the combinational send-permitted word.
// Assumes: masks are zero when no write targets this instance. If set and
// clear hit the same bit at once, set wins.
module doorbell_chan_bank #(
    parameter int unsigned CH = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CH-1:0] pnd_set_i,
    input  logic [CH-1:0] pnd_clr_i,
    input  logic [CH-1:0] en_set_i,
    input  logic [CH-1:0] en_clr_i,
    output logic [CH-1:0] pnd_o,
    output logic [CH-1:0] en_o,
    output logic          irq_o,
    output logic [CH-1:0] send_ok_o
);
    logic [CH-1:0] pnd_q, en_q;
    logic          irq_q;

    // Apply clear masks first, then set masks, to both words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pnd_q <= '0;
            en_q  <= '0;
        end else begin
            pnd_q <= (pnd_q & ~pnd_clr_i) | pnd_set_i;
            en_q  <= (en_q & ~en_clr_i) | en_set_i;
        end
    end

    // Register the interrupt from the current pending and enable words.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(pnd_q & en_q);
    end

    // Expose state and the per-channel send-permitted word.
    always_comb begin
        pnd_o     = pnd_q;
        en_o      = en_q;
        irq_o     = irq_q;
        send_ok_o = en_q & ~pnd_q;
    end

    // R1: reset clears all state
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (pnd_q == '0 && en_q == '0 && !irq_q));

    // R2: set bits land in the pending word
    assert_pnd_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pnd_set_i != '0) |=> ((pnd_q & $past(pnd_set_i)) == $past(pnd_set_i)));

    // R2: set bits land in the enable word
    assert_en_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_set_i != '0) |=> ((en_q & $past(en_set_i)) == $past(en_set_i)));

    // R2/R3: bits not named by a mask keep their value
    assert_untouched_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pnd_q ^ $past(pnd_q)) & ~$past(pnd_set_i | pnd_clr_i)) == '0));

    // R3: cleared bits drop in the pending word
    assert_pnd_clr_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pnd_clr_i & ~pnd_set_i) != '0) |=> ((pnd_q & $past(pnd_clr_i & ~pnd_set_i)) == '0));

    // R6: sustained pending-and-enabled state leaves the interrupt high
    assert_irq_sustained_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pnd_q & en_q) != '0 && $past((pnd_q & en_q) != '0)) |-> irq_q);

endmodule

// File: rtl/doorbell_mailbox.sv
// Module: doorbell_mailbox (top)
// Purpose: a memory-mapped doorbell controller with NUM_INST instances of CH
// channels each. It decodes single-cycle accesses into per-instance set and
// clear masks and answers each access one cycle later with ready and read data.
// Assumes: bus_sel is held for one cycle per access; every access completes.
module doorbell_mailbox
    import doorbell_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned NUM_INST = 4,
    parameter int unsigned CH       = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_sel,
    input  logic                   bus_we,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [CH-1:0]          bus_wdata,
    output logic [CH-1:0]          bus_rdata,
    output logic                   bus_ready,
    output logic [NUM_INST-1:0]    irq,
    output logic [NUM_INST*CH-1:0] send_ok
);
    localparam int unsigned IDX_W = $clog2(BANK_STRIDE) - $clog2(REG_STRIDE);

    logic             dec_hit;
    bank_e            dec_bank;
    logic [IDX_W-1:0] dec_inst;
    logic             wr_go;
    logic [CH-1:0]    pnd_w [NUM_INST];
    logic [CH-1:0]    en_w  [NUM_INST];
    logic [CH-1:0]    rd_val;
    logic [CH-1:0]    rdata_q;
    logic             ready_q;

    doorbell_decode #(.ADDR_W(ADDR_W), .NUM_INST(NUM_INST)) u_decode (
        .addr_i (bus_addr),
        .hit_o  (dec_hit),
        .bank_o (dec_bank),
        .inst_o (dec_inst)
    );

    // A write takes effect only when it hits a mapped register.
    always_comb wr_go = bus_sel && bus_we && dec_hit;

    for (genvar gi = 0; gi < NUM_INST; gi++) begin : g_inst
        logic          mine;
        logic [CH-1:0] m_pset, m_pclr, m_eset, m_eclr;

        // Steer write data into this instance's masks by bank code.
        always_comb begin
            mine   = wr_go && (dec_inst == IDX_W'(gi));
            m_pset = (mine && dec_bank == BK_PND_SET) ? bus_wdata : '0;
            m_pclr = (mine && dec_bank == BK_PND_CLR) ? bus_wdata : '0;
            m_eset = (mine && dec_bank == BK_EN_SET)  ? bus_wdata : '0;
            m_eclr = (mine && dec_bank == BK_EN_CLR)  ? bus_wdata : '0;
        end

        doorbell_chan_bank #(.CH(CH)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .pnd_set_i (m_pset),
            .pnd_clr_i (m_pclr),
            .en_set_i  (m_eset),
            .en_clr_i  (m_eclr),
            .pnd_o     (pnd_w[gi]),
            .en_o      (en_w[gi]),
            .irq_o     (irq[gi]),
            .send_ok_o (send_ok[gi*CH +: CH])
        );
    end

    // Select read data; only the value banks return state.
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_INST; i++) begin
            if (dec_hit && dec_inst == IDX_W'(i)) begin
                if (dec_bank == BK_PND_VAL)     rd_val = pnd_w[i];
                else if (dec_bank == BK_EN_VAL) rd_val = en_w[i];
            end
        end
    end

    // Register the response: ready for every access, data only for reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            ready_q <= bus_sel;
            rdata_q <= (bus_sel && !bus_we) ? rd_val : '0;
        end
    end

    always_comb begin
        bus_ready = ready_q;
        bus_rdata = rdata_q;
    end

    // R8: every access is answered in the next cycle
    assert_access_answered_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |=> bus_ready);

    // R8: no access means a quiet response
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> (!bus_ready && bus_rdata == '0));

    // R5: writes never return data
    assert_write_no_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we) |=> (bus_rdata == '0));

    // R5: unmapped reads return zero
    assert_unmapped_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && !dec_hit) |=> (bus_rdata == '0));

endmodule

// File: tb/doorbell_mailbox_bench.sv
`timescale 1ns/1ps
module doorbell_mailbox_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0;
    logic         bus_we = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         bus_ready;
    logic [3:0]   irq;
    logic [127:0] send_ok;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] m_pnd [4];
    logic [31:0] m_en  [4];

    always #4 clk = ~clk;

    doorbell_mailbox u_doorbell_mailbox (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .irq(irq), .send_ok(send_ok)
    );

    function automatic logic [7:0] reg_at(int b, int i);
        return 8'(4 + 32*b + 4*i);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin m_pnd[i] = '0; m_en[i] = '0; end
    endtask

    // Single-cycle write; returns at the negedge after the accepting edge.
    task automatic bus_wr(logic [7:0] a, logic [31:0] d);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
        for (int i = 0; i < 4; i++) begin
            if (a == reg_at(1, i)) m_pnd[i] = m_pnd[i] | d;
            if (a == reg_at(2, i)) m_pnd[i] = m_pnd[i] & ~d;
            if (a == reg_at(4, i)) m_en[i]  = m_en[i] | d;
            if (a == reg_at(5, i)) m_en[i]  = m_en[i] & ~d;
        end
    endtask

    task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic check_state(string req);
        logic [31:0] v;
        for (int i = 0; i < 4; i++) begin
            bus_rd(reg_at(0, i), v); check(req, v, m_pnd[i]);
            bus_rd(reg_at(3, i), v); check(req, v, m_en[i]);
        end
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    task automatic t_reset();
        check("R1 irq", 32'(irq), 32'h0);
        for (int i = 0; i < 4; i++) check("R1 send_ok", send_ok[i*32 +: 32], 32'h0);
        check_state("R1 state");
    endtask

    task automatic t_set_clear();
        bus_wr(reg_at(4, 0), 32'hF0F0_0001);
        check("R2 en set", send_ok[31:0], 32'hF0F0_0001);
        bus_wr(reg_at(4, 0), 32'h0000_0100);
        check("R2 zeros keep", send_ok[31:0], 32'hF0F0_0101);
        bus_wr(reg_at(5, 0), 32'h0000_0001);
        check("R3 en clear", send_ok[31:0], 32'hF0F0_0100);
        bus_wr(reg_at(1, 0), 32'h00F0_0000);
        bus_wr(reg_at(2, 0), 32'h0030_0000);
        check_state("R2/R3 readback");
    endtask

    task automatic t_irq();
        logic [31:0] v;
        bus_wr(reg_at(2, 0), 32'hFFFF_FFFF);
        @(negedge clk);
        check("R6 idle irq0", 32'(irq[0]), 32'h0);
        bus_wr(reg_at(1, 0), 32'h0000_0100);
        check("R6 irq0 not yet", 32'(irq[0]), 32'h0);
        check("R7 busy bit", send_ok[31:0], 32'hF0F0_0000);
        @(negedge clk);
        check("R6 irq0 rises", 32'(irq[0]), 32'h1);
        bus_wr(reg_at(1, 1), 32'h8000_0000);
        @(negedge clk);
        check("R6 disabled pending", 32'(irq[1]), 32'h0);
        bus_wr(reg_at(4, 1), 32'h8000_0000);
        check("R7 pending enabled", send_ok[63:32], 32'h0);
        @(negedge clk);
        check("R6 irq1 rises", 32'(irq[1]), 32'h1);
        bus_wr(reg_at(2, 0), 32'h0000_0100);
        check("R6 irq0 holds", 32'(irq[0]), 32'h1);
        check("R7 free again", send_ok[31:0], 32'hF0F0_0100);
        @(negedge clk);
        check("R6 irq0 falls", 32'(irq[0]), 32'h0);
        bus_rd(reg_at(0, 1), v);
        check("R6 pend kept", v, 32'h8000_0000);
    endtask

    task automatic t_map();
        do_reset();
        for (int i = 0; i < 4; i++) bus_wr(reg_at(1, i), 32'h1 << (3*i + 1));
        for (int i = 0; i < 4; i++) bus_wr(reg_at(4, i), 32'hA5 << (4*i));
        check_state("R4/R9 map");
        bus_wr(reg_at(2, 2), 32'hFFFF_FFFF);
        check_state("R9 isolation");
        for (int i = 0; i < 4; i++)
            check("R7 per inst", send_ok[i*32 +: 32], m_en[i] & ~m_pnd[i]);
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        bus_wr(reg_at(0, 0), 32'hFFFF_FFFF);
        bus_wr(reg_at(3, 1), 32'hFFFF_FFFF);
        bus_wr(8'h14, 32'hFFFF_FFFF);
        bus_wr(8'h25, 32'hFFFF_FFFF);
        bus_wr(8'hC4, 32'hFFFF_FFFF);
        bus_wr(8'h00, 32'hFFFF_FFFF);
        check_state("R5 ignored writes");
        bus_rd(reg_at(1, 0), v); check("R5 set reads 0", v, 32'h0);
        bus_rd(reg_at(5, 3), v); check("R5 clr reads 0", v, 32'h0);
        bus_rd(8'h14, v);        check("R5 unmapped 0", v, 32'h0);
        bus_rd(8'h65, v);        check("R5 misaligned 0", v, 32'h0);
    endtask

    task automatic t_handshake();
        logic [31:0] v;
        @(negedge clk);
        check("R8 idle ready", 32'(bus_ready), 32'h0);
        bus_sel = 1; bus_we = 0; bus_addr = reg_at(3, 0);
        @(negedge clk);
        check("R8 ready pulse", 32'(bus_ready), 32'h1);
        check("R8 read data", bus_rdata, m_en[0]);
        bus_sel = 0;
        @(negedge clk);
        check("R8 ready drops", 32'(bus_ready), 32'h0);
        check("R8 data cleared", bus_rdata, 32'h0);
        bus_wr(reg_at(4, 3), 32'h1);
        check("R8 write ready", 32'(bus_ready), 32'h1);
        check("R8 write no data", bus_rdata, 32'h0);
        bus_rd(reg_at(3, 3), v);
        check("R8 readback", v, m_en[3]);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        model_reset();
        do_reset();
        t_reset();
        t_set_clear();
        t_irq();
        t_map();
        t_ignored();
        t_handshake();
        do_reset();
        t_reset();
        done = 1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            summary();
        end
    end

endmodule